// File: doc/BRIEF.md
# Software write protection sequencer

This block sits between the host's byte-write strobes and the page write controller of a parallel non-volatile memory. It observes each write as an address and a data byte, together with a timeout marker that says the byte-load window since the previous write has run out. It holds a protection flag, and it raises a write permit for each write that the page buffer may accept.

Three fixed command writes turn protection on. Six fixed command writes turn it off. While protection is on, a page of writes is accepted only if the three-write unlock sequence comes directly before it. That permission ends when the page's program cycle starts, or when the byte-load window expires. The protection flag stands in for a non-volatile bit. Reset clears the command matcher and the unlock window but leaves the flag untouched, and the flag is clear when the part first powers up.

Top module: `wprot_seq`

## Requirements
- R1: `wr_permit` is low in every cycle where `wr_stb` is low. While `prot_on` is 0, every strobed write is permitted, including command bytes and writes that break a sequence.
- R2: The writes 0xAA to address 0x1555, then 0x55 to 0x0AAA, then 0xA0 to 0x1555 set `prot_on` to 1 from the cycle after the third write. No further write is needed for this to happen.
- R3: While `prot_on` is 1 and no unlock window is open, strobed writes are refused. This includes the command bytes themselves.
- R4: While `prot_on` is 1, completing the three-write sequence opens an unlock window. Every strobed write inside that window is permitted.
- R5: The six writes 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 clear `prot_on` from the cycle after the sixth write. A write in that very cycle is already permitted.
- R6: A cycle with `blc_tmo` high ends any partly matched sequence and closes the unlock window. A write strobed in that same cycle is judged as the first write after the timeout.
- R7: A wrong address or a wrong data byte partway through a sequence returns the matcher to idle, so the rest of that sequence has no effect.
- R8: `rst_n` low clears the matcher and the unlock window, and `wr_permit` is 0 while it is low. `prot_on` keeps its value through reset. It starts at 0 at first power-up.
- R9: A cycle with `prog_start` high closes the unlock window. A later write needs a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset; does not touch the protection flag |
| wr_stb | input | 1 | One write is presented this cycle |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data |
| blc_tmo | input | 1 | Byte-load window expired before this cycle's write |
| prog_start | input | 1 | The page program cycle begins |
| wr_permit | output | 1 | The write in this cycle may enter the page buffer |
| prot_on | output | 1 | Protection flag |

## Verification
The matcher is driven with four kinds of stream:
- Complete sequences, which separate the on and off transitions of the flag.
- Sequences broken by a wrong address or data byte, which show that partial matches are dropped.
- Sequences split by a timeout, which show that the byte-load window bounds a sequence.
- Ordinary data writes before and after an unlock, which tell a granted page apart from a refused one.

After an unlock, a program-start pulse or a timeout shows when the window closes. A reset taken while protected shows that the flag survives while the window does not.

// File: rtl/wps_pkg.sv
package wps_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_K1    = 3'd1,
      SQ_K2    = 3'd2,
      SQ_X3    = 3'd3,
      SQ_X4    = 3'd4,
      SQ_X5    = 3'd5
   } sq_state_t;

   localparam int CK_LEAD   = 0;
   localparam int CK_SECOND = 1;
   localparam int CK_LOCK   = 2;
   localparam int CK_ERASE  = 3;
   localparam int CK_CLEAR  = 4;
   localparam int NUM_CMD   = 5;

endpackage

// File: rtl/wps_cmd_decode.sv
module wps_cmd_decode
   import wps_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] ADDR_P = 'h1555,
   parameter logic [ADDR_W-1:0] ADDR_Q = 'h0AAA,
   parameter logic [DATA_W-1:0] D_LEAD   = 'hAA,
   parameter logic [DATA_W-1:0] D_SECOND = 'h55,
   parameter logic [DATA_W-1:0] D_LOCK   = 'hA0,
   parameter logic [DATA_W-1:0] D_ERASE  = 'h80,
   parameter logic [DATA_W-1:0] D_CLEAR  = 'h20
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  data,
   output logic [NUM_CMD-1:0] hit
);

   for (genvar gi = 0; gi < NUM_CMD; gi++) begin : g_cmp
      localparam logic [ADDR_W-1:0] CA = (gi == CK_SECOND) ? ADDR_Q : ADDR_P;
      localparam logic [DATA_W-1:0] CD =
         (gi == CK_LEAD)   ? D_LEAD   :
         (gi == CK_SECOND) ? D_SECOND :
         (gi == CK_LOCK)   ? D_LOCK   :
         (gi == CK_ERASE)  ? D_ERASE  : D_CLEAR;
      assign hit[gi] = (addr == CA) && (data == CD);
   end

endmodule

// File: rtl/wps_seq_fsm.sv
module wps_seq_fsm
   import wps_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stb,
   input  logic               tmo,
   input  logic [NUM_CMD-1:0] hit,
   output logic               fire_lock,
   output logic               fire_clear
);

   sq_state_t st_q, st_eff, st_nxt;

   // a timeout ends whatever was matched before this cycle's write
   assign st_eff = tmo ? SQ_IDLE : st_q;

   always_comb begin
      st_nxt     = st_eff;
      fire_lock  = 1'b0;
      fire_clear = 1'b0;
      if (stb) begin
         st_nxt = SQ_IDLE;
         unique case (st_eff)
            SQ_IDLE: if (hit[CK_LEAD])   st_nxt = SQ_K1;
            SQ_K1:   if (hit[CK_SECOND]) st_nxt = SQ_K2;
            SQ_K2: begin
               if (hit[CK_LOCK])       fire_lock = 1'b1;
               else if (hit[CK_ERASE]) st_nxt = SQ_X3;
            end
            SQ_X3:   if (hit[CK_LEAD])   st_nxt = SQ_X4;
            SQ_X4:   if (hit[CK_SECOND]) st_nxt = SQ_X5;
            SQ_X5:   if (hit[CK_CLEAR])  fire_clear = 1'b1;
            default: st_nxt = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_nxt;
   end

endmodule

// File: rtl/wps_prot_store.sv
module wps_prot_store #(
   parameter bit SHIP_PROT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic tmo,
   input  logic prog,
   input  logic fire_lock,
   input  logic fire_clear,
   output logic prot_on,
   output logic permit
);

   // stands in for a non-volatile cell: initial value only, never reset
   logic prot_q = SHIP_PROT;
   logic unlock_q;
   logic unlock_eff;

   always_ff @(posedge clk) begin
      if (rst_n) begin
         if (fire_lock)       prot_q <= 1'b1;
         else if (fire_clear) prot_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                         unlock_q <= 1'b0;
      else if (fire_lock)                 unlock_q <= 1'b1;
      else if (fire_clear || tmo || prog) unlock_q <= 1'b0;
   end

   assign unlock_eff = unlock_q && !tmo && !prog;
   assign permit     = rst_n && stb && (!prot_q || unlock_eff);
   assign prot_on    = prot_q;

endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
   import wps_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] ADDR_P = 'h1555,
   parameter logic [ADDR_W-1:0] ADDR_Q = 'h0AAA,
   parameter logic [DATA_W-1:0] D_LEAD   = 'hAA,
   parameter logic [DATA_W-1:0] D_SECOND = 'h55,
   parameter logic [DATA_W-1:0] D_LOCK   = 'hA0,
   parameter logic [DATA_W-1:0] D_ERASE  = 'h80,
   parameter logic [DATA_W-1:0] D_CLEAR  = 'h20,
   parameter bit SHIP_PROT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              blc_tmo,
   input  logic              prog_start,
   output logic              wr_permit,
   output logic              prot_on
);

   if (ADDR_W < 2) begin : g_bad_aw
      $error("wprot_seq: ADDR_W too small");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("wprot_seq: DATA_W too small");
   end
   if (ADDR_P == ADDR_Q) begin : g_bad_addr
      $error("wprot_seq: command addresses must differ");
   end
   if (D_LOCK == D_ERASE || D_LEAD == D_SECOND) begin : g_bad_code
      $error("wprot_seq: ambiguous command codes");
   end

   logic [NUM_CMD-1:0] hit;
   logic               fire_lock;
   logic               fire_clear;

   wps_cmd_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .ADDR_P(ADDR_P), .ADDR_Q(ADDR_Q),
      .D_LEAD(D_LEAD), .D_SECOND(D_SECOND), .D_LOCK(D_LOCK),
      .D_ERASE(D_ERASE), .D_CLEAR(D_CLEAR)
   ) u_dec (
      .addr (wr_addr),
      .data (wr_data),
      .hit  (hit)
   );

   wps_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        (wr_stb),
      .tmo        (blc_tmo),
      .hit        (hit),
      .fire_lock  (fire_lock),
      .fire_clear (fire_clear)
   );

   wps_prot_store #(.SHIP_PROT(SHIP_PROT)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        (wr_stb),
      .tmo        (blc_tmo),
      .prog       (prog_start),
      .fire_lock  (fire_lock),
      .fire_clear (fire_clear),
      .prot_on    (prot_on),
      .permit     (wr_permit)
   );

endmodule

// File: rtl/wps_sva.sv
module wps_sva #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] ADDR_P = 'h1555,
   parameter logic [DATA_W-1:0] D_LOCK  = 'hA0,
   parameter logic [DATA_W-1:0] D_CLEAR = 'h20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              blc_tmo,
   input logic              prog_start,
   input logic              wr_permit,
   input logic              prot_on
);

   p_permit_needs_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |-> !wr_permit);

   p_open_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !prot_on) |-> wr_permit);

   p_lock_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_on) |-> $past(wr_stb && wr_addr == ADDR_P && wr_data == D_LOCK));

   p_clear_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_on) |-> $past(wr_stb && wr_addr == ADDR_P && wr_data == D_CLEAR));

   p_tmo_shuts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && blc_tmo) |-> !wr_permit);

   p_prog_shuts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && prog_start) |-> !wr_permit);

   p_flag_held_r8: assert property (@(posedge clk)
      !rst_n |=> (prot_on == $past(prot_on)));

endmodule

bind wprot_seq wps_sva #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_P(ADDR_P),
   .D_LOCK(D_LOCK), .D_CLEAR(D_CLEAR)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .blc_tmo    (blc_tmo),
   .prog_start (prog_start),
   .wr_permit  (wr_permit),
   .prot_on    (prot_on)
);

// File: tb/sim_wprot_seq.sv
module sim_wprot_seq;

   typedef struct packed {
      logic        stb;
      logic        tmo;
      logic        prog;
      logic [12:0] a;
      logic [7:0]  d;
      logic        perm;
      logic        prot;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b0,4'd1},  // 0  R1 idle, no permit
      '{1'b1,1'b0,1'b0,13'h0123,8'h5A,1'b1,1'b0,4'd1},  // 1  R1 plain write when off
      '{1'b1,1'b0,1'b0,13'h1555,8'hAA,1'b1,1'b0,4'd1},  // 2  R1 command bytes written
      '{1'b1,1'b0,1'b0,13'h0AAA,8'h55,1'b1,1'b0,4'd1},  // 3
      '{1'b1,1'b0,1'b0,13'h1555,8'hA0,1'b1,1'b1,4'd2},  // 4  R2 protection on
      '{1'b1,1'b0,1'b0,13'h0040,8'h11,1'b1,1'b1,4'd4},  // 5  R4 window open
      '{1'b1,1'b0,1'b0,13'h0041,8'h22,1'b1,1'b1,4'd4},  // 6
      '{1'b0,1'b0,1'b1,13'h0000,8'h00,1'b0,1'b1,4'd9},  // 7  R9 program starts
      '{1'b1,1'b0,1'b0,13'h0042,8'h33,1'b0,1'b1,4'd9},  // 8  R9 window closed
      '{1'b1,1'b0,1'b0,13'h1555,8'hAA,1'b0,1'b1,4'd3},  // 9  R3 command refused
      '{1'b1,1'b0,1'b0,13'h0AAA,8'h55,1'b0,1'b1,4'd3},  // 10
      '{1'b1,1'b0,1'b0,13'h1555,8'hA0,1'b0,1'b1,4'd3},  // 11
      '{1'b1,1'b0,1'b0,13'h0050,8'h44,1'b1,1'b1,4'd4},  // 12 R4 unlocked page
      '{1'b1,1'b1,1'b0,13'h0051,8'h55,1'b0,1'b1,4'd6},  // 13 R6 timeout ends window
      '{1'b1,1'b0,1'b0,13'h1555,8'hAA,1'b0,1'b1,4'd3},  // 14
      '{1'b1,1'b1,1'b0,13'h0AAA,8'h55,1'b0,1'b1,4'd6},  // 15 R6 timeout mid-sequence
      '{1'b1,1'b0,1'b0,13'h1555,8'hA0,1'b0,1'b1,4'd6},  // 16
      '{1'b1,1'b0,1'b0,13'h0060,8'h01,1'b0,1'b1,4'd6},  // 17 R6 no unlock
      '{1'b1,1'b0,1'b0,13'h1555,8'hAA,1'b0,1'b1,4'd7},  // 18
      '{1'b1,1'b0,1'b0,13'h0AAB,8'h55,1'b0,1'b1,4'd7},  // 19 R7 wrong address
      '{1'b1,1'b0,1'b0,13'h1555,8'hA0,1'b0,1'b1,4'd7},  // 20
      '{1'b1,1'b0,1'b0,13'h0061,8'h02,1'b0,1'b1,4'd7},  // 21 R7 no unlock
      '{1'b1,1'b0,1'b0,13'h1555,8'hAA,1'b0,1'b1,4'd5},  // 22 R5 disable sequence
      '{1'b1,1'b0,1'b0,13'h0AAA,8'h55,1'b0,1'b1,4'd5},  // 23
      '{1'b1,1'b0,1'b0,13'h1555,8'h80,1'b0,1'b1,4'd5},  // 24
      '{1'b1,1'b0,1'b0,13'h1555,8'hAA,1'b0,1'b1,4'd5},  // 25
      '{1'b1,1'b0,1'b0,13'h0AAA,8'h55,1'b0,1'b1,4'd5},  // 26
      '{1'b1,1'b0,1'b0,13'h1555,8'h20,1'b0,1'b0,4'd5},  // 27 R5 protection off
      '{1'b1,1'b0,1'b0,13'h0070,8'h77,1'b1,1'b0,4'd5},  // 28 R5 write right after
      '{1'b1,1'b0,1'b0,13'h1555,8'hAA,1'b1,1'b0,4'd7},  // 29
      '{1'b1,1'b0,1'b0,13'h0AAA,8'h56,1'b1,1'b0,4'd7}   // 30 R7 wrong data, still written
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [12:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        blc_tmo = 1'b0;
   logic        prog_start = 1'b0;
   logic        wr_permit;
   logic        prot_on;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wprot_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .blc_tmo(blc_tmo), .prog_start(prog_start),
      .wr_permit(wr_permit), .prot_on(prot_on)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1; wr_addr = a; wr_data = d; blc_tmo = 1'b0; prog_start = 1'b0;
   endtask

   task automatic quiet();
      @(negedge clk);
      wr_stb = 1'b0; blc_tmo = 1'b0; prog_start = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R8 first power-up: unprotected, nothing permitted in reset
      check("R8", "prot_on at power-up", prot_on, 1'b0);
      check("R8", "permit held in reset", wr_permit, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         wr_stb = VEC[i].stb; blc_tmo = VEC[i].tmo; prog_start = VEC[i].prog;
         wr_addr = VEC[i].a; wr_data = VEC[i].d;
         #1;
         check($sformatf("R%0d", VEC[i].req), $sformatf("row %0d permit", i),
               wr_permit, VEC[i].perm);
         @(posedge clk);
         #1;
         check($sformatf("R%0d", VEC[i].req), $sformatf("row %0d prot_on", i),
               prot_on, VEC[i].prot);
      end

      // R2 enable, then R8 reset keeps the flag but drops the window
      quiet();
      put(13'h1555, 8'hAA); put(13'h0AAA, 8'h55); put(13'h1555, 8'hA0);
      quiet();
      #1 check("R2", "prot after enable, no further write", prot_on, 1'b1);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R8", "prot kept through reset", prot_on, 1'b1);
      rst_n = 1'b1;
      put(13'h0011, 8'h99);
      #1 check("R8", "window cleared by reset", wr_permit, 1'b0);

      // R4 window survives idle cycles, then a fresh unlock works after reset
      put(13'h1555, 8'hAA); put(13'h0AAA, 8'h55); put(13'h1555, 8'hA0);
      quiet(); quiet();
      put(13'h0012, 8'h98);
      #1 check("R4", "window across idle cycles", wr_permit, 1'b1);

      // R5 disable while unlocked, then reset: flag stays 0
      put(13'h1555, 8'hAA); put(13'h0AAA, 8'h55); put(13'h1555, 8'h80);
      put(13'h1555, 8'hAA); put(13'h0AAA, 8'h55); put(13'h1555, 8'h20);
      quiet();
      #1 check("R5", "prot off after disable", prot_on, 1'b0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R8", "cleared flag kept through reset", prot_on, 1'b0);
      rst_n = 1'b1;
      put(13'h0013, 8'h97);
      #1 check("R1", "write after reset when off", wr_permit, 1'b1);
      quiet();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule